// File: doc/BRIEF.md
# Wiper and Preset Register Bank

This block keeps the digital state behind a 1024-position potentiometer: one volatile 10-bit wiper code that selects the active tap, and four 10-bit preset slots that stand in for nonvolatile cells. A command decoder sends it requests as single-cycle strokes. These requests read registers, load the wiper, copy between the wiper and a preset slot, or write a preset. The decoder also reports the stop condition that closes each bus transaction.

The two copy directions have different costs. A preset-to-wiper copy or a direct wiper load is a volatile update. The tap output follows it after a short programmable settling delay. A preset write, or a copy of the wiper into a preset, only arms a pending write. That write starts at the next stop. It then holds `busy` high for a programmable number of cycles and commits when `busy` drops. While `busy` is high, every request is refused, so the bus side can withhold its acknowledge. A low write-protect input blocks preset writes but still lets wiper loads through. After reset, preset slot 0 is recalled into the wiper.

Top module: `wiper_preset_bank`

## Requirements
- R1: While reset is held and right after it, `busy` and `rd_valid` are low and `tap_sel` selects tap 0.
- R2: On the first clock after reset is released, the wiper takes the value of preset slot 0. `tap_sel` shows that value WIPER_DLY clocks later.
- R3: An accepted read is op code 1 (wiper) or op code 3 (preset slot `req_sel`). It raises `rd_valid` for one cycle on the next clock, with the addressed register's value on `rd_data`.
- R4: Op code 2 loads `req_data` into the wiper at once. `tap_sel` changes to the new code exactly WIPER_DLY clocks after the accepting clock and not earlier.
- R5: Op code 5 copies preset slot `req_sel` into the wiper, with the same tap delay as R4.
- R6: `tap_sel` always has exactly one bit set, and that bit is the displayed code. Code 0x000 is bit 0 (low end) and code 0x3FF is bit 1023 (high end).
- R7: Op code 4 (write `req_data` to slot `req_sel`) only arms a write. `busy` rises on the clock that samples `stop_seen` while the write is armed, stays high for NV_CYC cycles, and the slot is updated as `busy` falls. Any other accepted request before the stop cancels the armed write, and then a later stop does nothing.
- R8: While `busy` is high, requests are ignored. No `rd_valid` is produced, and neither the wiper nor the tap changes.
- R9: When `wp_n` is low at acceptance, op codes 4 and 6 have no effect: no `busy`, and the preset is unchanged. Op codes 2 and 5 still load the wiper.
- R10: Op code 6 writes the wiper's value into preset slot `req_sel`, with the armed, stop and busy timing of R7.
- R11: Op codes 0 and 7 are accepted but change no register and produce no read result.
- R12: A wiper load that arrives while an earlier load's tap delay is still running restarts the delay. The earlier code never appears on `tap_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request stroke, one cycle per request |
| req_op | input | 3 | Op code (see requirements) |
| req_sel | input | 2 | Preset slot pointer |
| req_data | input | 10 | Data for wiper or preset writes |
| stop_seen | input | 1 | Pulse when the bus transaction ends |
| wp_n | input | 1 | Write protect, low blocks preset writes |
| busy | output | 1 | Nonvolatile write cycle in progress |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 10 | Read result |
| tap_sel | output | 1024 | One-hot tap select |

## Verification
The hardest case to reach is a request arriving inside a nonvolatile write cycle. It only exists after a write has been armed, a stop has been given, and the window is still open. The stimulus arms a preset write, pulses the stop, and then fires a read, a wiper load and a recall back to back inside the busy window. Afterwards it confirms through reads and the tap output that none of them had any effect. A second hard case is a write that is armed and then cancelled. It is reached by putting a read between the write request and the stop.

// File: rtl/wpb_pkg.sv
`timescale 1ns/1ps
package wpb_pkg;
    localparam int WPB_DW   = 10;
    localparam int WPB_NPRE = 4;
    localparam int WPB_PW   = $clog2(WPB_NPRE);
    localparam int WPB_NTAP = 1 << WPB_DW;

    typedef logic [WPB_DW-1:0] code_t;
    typedef logic [WPB_PW-1:0] ptr_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_RD_WIPER = 3'd1,
        OP_WR_WIPER = 3'd2,
        OP_RD_SLOT  = 3'd3,
        OP_WR_SLOT  = 3'd4,
        OP_RECALL   = 3'd5,
        OP_STORE    = 3'd6,
        OP_RSVD     = 3'd7
    } wpb_op_e;

    typedef struct packed {
        ptr_t  sel;
        code_t data;
    } nv_req_t;

    function automatic logic op_is_nv(wpb_op_e op);
        return (op == OP_WR_SLOT) || (op == OP_STORE);
    endfunction

    function automatic logic op_is_read(wpb_op_e op);
        return (op == OP_RD_WIPER) || (op == OP_RD_SLOT);
    endfunction

    function automatic logic op_loads_wiper(wpb_op_e op);
        return (op == OP_WR_WIPER) || (op == OP_RECALL);
    endfunction
endpackage

// File: rtl/wpb_nv_sequencer.sv
`timescale 1ns/1ps
module wpb_nv_sequencer
    import wpb_pkg::*;
#(
    parameter int NV_CYC = 500000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    arm,
    input  nv_req_t arm_req,
    input  logic    cancel,
    input  logic    stop,
    output logic    busy,
    output logic    commit,
    output nv_req_t commit_req
);
    localparam int CW = $clog2(NV_CYC + 1);

    logic          pend_q;
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    nv_req_t       req_q;

    assign busy       = busy_q;
    assign commit     = busy_q && (cnt_q == CW'(1));
    assign commit_req = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            req_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) busy_q <= 1'b0;
        end else if (stop && pend_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(NV_CYC);
            pend_q <= 1'b0;
        end else if (arm) begin
            pend_q <= 1'b1;
            req_q  <= arm_req;
        end else if (cancel || stop) begin
            pend_q <= 1'b0;
        end
    end

    // R7: a write cycle only begins on a stop that finds a write armed
    a_r7_busy_needs_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(stop && pend_q));

    // R7: the commit stroke is the last busy cycle
    a_r7_commit_ends_busy: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy_q);
endmodule

// File: rtl/wpb_tap_follow.sv
`timescale 1ns/1ps
module wpb_tap_follow
    import wpb_pkg::*;
#(
    parameter int WIPER_DLY = 800
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  code_t               load_code,
    output logic [WPB_NTAP-1:0] tap_sel
);
    localparam int DCW = $clog2(WIPER_DLY + 1);

    code_t          staged_q;
    code_t          shown_q;
    logic [DCW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            shown_q  <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            staged_q <= load_code;
            cnt_q    <= DCW'(WIPER_DLY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DCW'(1);
            if (cnt_q == DCW'(1)) shown_q <= staged_q;
        end
    end

    for (genvar t = 0; t < WPB_NTAP; t++) begin : g_dec
        assign tap_sel[t] = (shown_q == WPB_DW'(t));
    end

    // R6: exactly one tap switch is closed at all times
    a_r6_single_tap: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1);

    // R4: the tap holds while the response delay is still running
    a_r4_tap_waits: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > DCW'(1)) |=> $stable(tap_sel));
endmodule

// File: rtl/wiper_preset_bank.sv
`timescale 1ns/1ps
module wiper_preset_bank
    import wpb_pkg::*;
#(
    parameter int NV_CYC    = 500000,
    parameter int WIPER_DLY = 800,
    parameter logic [WPB_NPRE*WPB_DW-1:0] PRESET_INIT =
        {10'h2C1, 10'h3FF, 10'h000, 10'h15A}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [WPB_PW-1:0]   req_sel,
    input  logic [WPB_DW-1:0]   req_data,
    input  logic                stop_seen,
    input  logic                wp_n,
    output logic                busy,
    output logic                rd_valid,
    output logic [WPB_DW-1:0]   rd_data,
    output logic [WPB_NTAP-1:0] tap_sel
);
    wpb_op_e op;
    code_t   wiper_q;
    code_t   slot_q [WPB_NPRE];
    logic    recall_q;
    logic    accept, nv_go, cancel, load_now, commit;
    code_t   load_val;
    nv_req_t arm_req, commit_req;

    assign op       = wpb_op_e'(req_op);
    assign accept   = req_valid && !busy && !recall_q;
    assign nv_go    = accept && op_is_nv(op) && wp_n;
    assign cancel   = accept && !nv_go;
    assign arm_req  = '{sel: req_sel, data: (op == OP_STORE) ? wiper_q : req_data};
    assign load_now = recall_q || (accept && op_loads_wiper(op));
    assign load_val = recall_q ? slot_q[0] :
                      (op == OP_WR_WIPER) ? req_data : slot_q[req_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper_q  <= '0;
            recall_q <= 1'b1;
        end else begin
            recall_q <= 1'b0;
            if (load_now) wiper_q <= load_val;
        end
    end

    for (genvar s = 0; s < WPB_NPRE; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= PRESET_INIT[s*WPB_DW +: WPB_DW];
            else if (commit && (commit_req.sel == WPB_PW'(s)))
                slot_q[s] <= commit_req.data;
        end

        // R7: a slot changes only on the commit stroke of a write cycle
        a_r7_slot_hold: assert property (@(posedge clk) disable iff (rst)
            !$past(commit) |-> $stable(slot_q[s]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= accept && op_is_read(op);
            if (accept && op_is_read(op))
                rd_data <= (op == OP_RD_WIPER) ? wiper_q : slot_q[req_sel];
        end
    end

    wpb_nv_sequencer #(.NV_CYC(NV_CYC)) i_seq (
        .clk(clk), .rst(rst), .arm(nv_go), .arm_req(arm_req),
        .cancel(cancel), .stop(stop_seen), .busy(busy),
        .commit(commit), .commit_req(commit_req)
    );

    wpb_tap_follow #(.WIPER_DLY(WIPER_DLY)) i_tap (
        .clk(clk), .rst(rst), .load(load_now), .load_code(load_val),
        .tap_sel(tap_sel)
    );

    // R8: the wiper is frozen through a write cycle
    a_r8_wiper_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wiper_q));

    // R9: a protected preset write never starts a write cycle
    a_r9_protect_no_busy: assert property (@(posedge clk) disable iff (rst)
        (accept && op_is_nv(op) && !wp_n && !stop_seen) |=> !busy);

    // R3: a read result only follows an accepted request
    a_r3_read_after_accept: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !busy));
endmodule

// File: tb/test_wiper_preset_bank.sv
`timescale 1ns/1ps
module test_wiper_preset_bank;
    import wpb_pkg::*;

    localparam int NVC = 20;
    localparam int DLY = 4;
    localparam logic [39:0] PINIT = {10'h2C1, 10'h3FF, 10'h000, 10'h15A};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_sel = '0;
    logic [9:0]  req_data = '0;
    logic        stop_seen = 1'b0;
    logic        wp_n = 1'b1;
    logic        busy, rd_valid;
    logic [9:0]  rd_data;
    logic [1023:0] tap_sel;

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic [9:0] m_pre [4];
    logic [9:0] m_wip;

    always #2.5 clk = ~clk;

    wiper_preset_bank #(.NV_CYC(NVC), .WIPER_DLY(DLY), .PRESET_INIT(PINIT)) i_wiper_preset_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_data(req_data), .stop_seen(stop_seen),
        .wp_n(wp_n), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .tap_sel(tap_sel)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic issue(logic [2:0] op, logic [1:0] sel, logic [9:0] data);
        req_valid = 1'b1; req_op = op; req_sel = sel; req_data = data;
        tick(1);
        req_valid = 1'b0; req_op = '0; req_sel = '0; req_data = '0;
    endtask

    task automatic rd_wiper(string tag);
        exp_q.push_back(m_wip); tag_q.push_back(tag);
        issue(3'd1, 2'd0, 10'h0);
    endtask

    task automatic rd_slot(string tag, logic [1:0] s);
        exp_q.push_back(m_pre[s]); tag_q.push_back(tag);
        issue(3'd3, s, 10'h0);
    endtask

    task automatic pulse_stop();
        stop_seen = 1'b1;
        tick(1);
        stop_seen = 1'b0;
    endtask

    task automatic chk_tap(string tag, int exp);
        int ones = 0;
        int idx = -1;
        for (int i = 0; i < 1024; i++) begin
            if (tap_sel[i]) begin
                ones++;
                idx = i;
            end
        end
        chk({tag, " one-hot"}, ones, 1);
        chk(tag, idx, exp);
    endtask

    // monitor: pops the scoreboard on each read result
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8/R11 unexpected read result actual=%0h expected=none", rd_data);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) m_pre[s] = PINIT[s*10 +: 10];
        m_wip = '0;
        tick(3);
        chk("R1 busy in reset", busy, 0);
        chk("R1 rd_valid in reset", rd_valid, 0);
        chk_tap("R1 tap in reset", 0);
        rst = 1'b0;
        tick(1);                       // recall clock
        m_wip = m_pre[0];
        chk("R1 busy after reset", busy, 0);
        tick(DLY - 1);
        chk_tap("R2 tap before delay", 0);
        tick(1);
        chk_tap("R2 tap shows recalled slot0", 10'h15A);

        rd_wiper("R3 read wiper");
        rd_slot("R3 read slot1", 2'd1);
        rd_slot("R3 read slot2", 2'd2);
        rd_slot("R3 read slot3", 2'd3);

        issue(3'd2, 2'd0, 10'h0AB); m_wip = 10'h0AB;
        tick(DLY - 1);
        chk_tap("R4 tap held during delay", 10'h15A);
        tick(1);
        chk_tap("R4 tap after delay", 10'h0AB);
        rd_wiper("R4 wiper readback");

        issue(3'd2, 2'd0, 10'h3FF); m_wip = 10'h3FF;
        tick(DLY);
        chk_tap("R6 high end", 1023);
        issue(3'd2, 2'd0, 10'h000); m_wip = 10'h000;
        tick(DLY);
        chk_tap("R6 low end", 0);

        issue(3'd2, 2'd0, 10'h100);
        tick(2);
        issue(3'd2, 2'd0, 10'h200); m_wip = 10'h200;
        tick(DLY - 1);
        chk_tap("R12 earlier load never shown", 0);
        tick(1);
        chk_tap("R12 latest load shown", 10'h200);

        issue(3'd5, 2'd2, 10'h000); m_wip = m_pre[2];
        tick(DLY - 1);
        chk_tap("R5 tap held during delay", 10'h200);
        tick(1);
        chk_tap("R5 recall slot2", 10'h3FF);
        rd_wiper("R5 wiper after recall");

        issue(3'd4, 2'd1, 10'h1C7);
        tick(3);
        chk("R7 no busy without stop", busy, 0);
        rd_slot("R7 slot1 before stop", 2'd1);
        pulse_stop();
        chk("R7 cancelled write no busy", busy, 0);
        rd_slot("R7 slot1 after cancel", 2'd1);

        issue(3'd4, 2'd1, 10'h1C7);
        pulse_stop();
        chk("R7 busy after stop", busy, 1);
        issue(3'd1, 2'd0, 10'h0);
        issue(3'd2, 2'd0, 10'h055);
        issue(3'd5, 2'd0, 10'h0);
        tick(NVC - 1 - 3);
        chk("R7 busy last cycle", busy, 1);
        tick(1);
        chk("R7 busy falls", busy, 0);
        m_pre[1] = 10'h1C7;
        rd_slot("R7 slot1 committed", 2'd1);
        rd_wiper("R8 wiper untouched by busy requests");
        tick(DLY + 1);
        chk_tap("R8 tap untouched by busy requests", 10'h3FF);

        issue(3'd2, 2'd0, 10'h2E4); m_wip = 10'h2E4;
        issue(3'd6, 2'd3, 10'h0);
        pulse_stop();
        chk("R10 store busy", busy, 1);
        tick(NVC);
        chk("R10 store done", busy, 0);
        m_pre[3] = 10'h2E4;
        rd_slot("R10 slot3 holds wiper", 2'd3);

        wp_n = 1'b0;
        issue(3'd4, 2'd0, 10'h3A3);
        pulse_stop();
        chk("R9 protected write no busy", busy, 0);
        issue(3'd6, 2'd2, 10'h0);
        pulse_stop();
        chk("R9 protected store no busy", busy, 0);
        issue(3'd2, 2'd0, 10'h077); m_wip = 10'h077;
        wp_n = 1'b1;
        rd_slot("R9 slot0 unchanged", 2'd0);
        rd_slot("R9 slot2 unchanged", 2'd2);
        rd_wiper("R9 wiper write still works");

        issue(3'd0, 2'd1, 10'h3FF);
        issue(3'd7, 2'd2, 10'h3FF);
        tick(DLY + 1);
        rd_wiper("R11 unused ops leave wiper");
        rd_slot("R11 unused ops leave slot2", 2'd2);
        chk_tap("R11 tap unchanged", 10'h077);

        tick(3);
        chk("R3 all reads answered", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule